// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block keeps the two 256-entry vector sets of a local interrupt controller. The pending set records requested vectors. The service set records vectors the processor has taken but not yet finished. Both outputs are driven combinationally from the stored bits, so each output always shows the highest vector in its set. A fixed-priority request sets its vector's bit in the pending set. An acknowledge moves the highest pending vector into the service set. An end-of-interrupt retires the highest vector in service.

Four special sources bypass the pending set: system management, non-maskable, init and external. Each has its own pending flag and its own stored vector. An external interrupt is the only one of the four that can be masked. A summary flag therefore gathers only the other three. Routing of messages and the processor-side interface belong to other blocks. A user drives the request port from the message decoder, pulses acknowledge or end-of-interrupt from the core, and clears a special flag with its own acknowledge bit once that source has been taken.

Top module: `irq_track`

## Requirements
- R1: After reset both sets are empty, both highest-vector outputs are 0, all four special flags and their stored vectors are 0, and the summary flag is 0.
- R2: A request with mode 0 or 1 sets bit v of the pending set, with v in word v>>5 and bit v&31. The pending output shows word*32 + the highest set bit of the highest non-zero word. Requesting a vector that is already pending changes nothing.
- R3: When a set is empty, its highest-vector output reads 0.
- R4: Acknowledge, when the pending set is not empty, clears the highest pending bit and sets the same vector in the service set in the same clock. Acknowledge on an empty pending set has no effect.
- R5: End-of-interrupt clears the highest bit of the service set. On an empty service set it has no effect.
- R6: Mode 2 (system management), 4 (non-maskable), 5 (init) and 7 (external) leave the pending set untouched. They set the source's flag, which is bit 0, 1, 2 or 3 of spc_pend, and latch the request vector into byte 0, 1, 2 or 3 of spc_vec. A later request of the same kind replaces the vector.
- R7: unmask_pend is high exactly when flag bit 0, 1 or 2 is set. The external flag (bit 3) does not affect it.
- R8: A high spc_ack bit clears that source's flag and leaves its stored vector unchanged.
- R9: When a set request and a clear hit the same bit or flag in one cycle, the clear wins and the request is lost. This covers a pending vector taken by acknowledge and a special flag that is acknowledged.
- R10: Requests with mode 3 or 6 are ignored. Neither set nor any flag changes.
- R11: Every output reflects an input one clock edge after that input is sampled, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronized inside |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_mode | input | 3 | Delivery mode of the request |
| ack | input | 1 | Move the highest pending vector into service |
| eoi | input | 1 | Retire the highest vector in service |
| spc_ack | input | 4 | Clear special flags: bit 0 system management, 1 non-maskable, 2 init, 3 external |
| top_req_vec | output | 8 | Highest pending vector, 0 when empty |
| top_svc_vec | output | 8 | Highest vector in service, 0 when empty |
| spc_pend | output | 4 | Special pending flags, same bit order as spc_ack |
| spc_vec | output | 32 | Stored special vectors, one byte per source |
| unmask_pend | output | 1 | Any of the three unmaskable flags is pending |

## Verification
A bit that is lost or stuck in either set shows on the highest-vector outputs by the time that vector becomes the highest. Acknowledge and end-of-interrupt make that happen: they peel the sets from the top down, so a wrong bit appears within as many operations as there are higher vectors. A bad mask or a bad scan shows on the first edge after the request that exposes it. A wrong special flag or vector appears on the next edge, because those outputs come straight from registers. The bench therefore compares every output against its own model after every single edge.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;

  localparam int unsigned NUM_SPC = 4;
  localparam int unsigned SPC_SMI = 0;
  localparam int unsigned SPC_NMI = 1;
  localparam int unsigned SPC_INI = 2;
  localparam int unsigned SPC_EXT = 3;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV6   = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  function automatic dmode_e spc_code(input int unsigned idx);
    case (idx)
      SPC_SMI: return DM_SMI;
      SPC_NMI: return DM_NMI;
      SPC_INI: return DM_INIT;
      default: return DM_EXT;
    endcase
  endfunction

endpackage

// File: rtl/irq_vec_set.sv
module irq_vec_set #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int OFF_W  = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [VEC_W-1:0]   set_vec,
  input  logic               clr_en,
  input  logic [VEC_W-1:0]   clr_vec,
  output logic [NUM_VEC-1:0] bits
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int WI_W      = VEC_W - OFF_W;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic              set_hit, clr_hit, word_en;
    logic [WORD_W-1:0] word_q, word_d;

    assign set_hit = set_en && (set_vec[VEC_W-1:OFF_W] == WI_W'(w));
    assign clr_hit = clr_en && (clr_vec[VEC_W-1:OFF_W] == WI_W'(w));
    assign word_en = set_hit || clr_hit;

    always_comb begin
      word_d = word_q;
      if (set_hit) word_d = word_d | (WORD_W'(1) << set_vec[OFF_W-1:0]);
      if (clr_hit) word_d = word_d & ~(WORD_W'(1) << clr_vec[OFF_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign bits[w*WORD_W +: WORD_W] = word_q;
  end

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !bits[$past(clr_vec)]);

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_en && clr_vec == set_vec)) |=> bits[$past(set_vec)]);

endmodule

// File: rtl/irq_msb_scan.sv
module irq_msb_scan #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int OFF_W  = $clog2(WORD_W)
) (
  input  logic [NUM_VEC-1:0] bits,
  output logic               any,
  output logic [VEC_W-1:0]   top
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;

  logic [NUM_WORDS-1:0]       nz;
  logic [NUM_WORDS*OFF_W-1:0] msb_flat;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [OFF_W-1:0] m;
    always_comb begin
      m = '0;
      for (int b = 0; b < WORD_W; b++)
        if (bits[w*WORD_W + b]) m = OFF_W'(b);
    end
    assign nz[w] = |bits[w*WORD_W +: WORD_W];
    assign msb_flat[w*OFF_W +: OFF_W] = m;
  end

  always_comb begin
    any = |nz;
    top = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (nz[w]) top = VEC_W'(w * WORD_W) | VEC_W'(msb_flat[w*OFF_W +: OFF_W]);
  end

endmodule

// File: rtl/irq_special_src.sv
module irq_special_src #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             clr,
  output logic             pend,
  output logic [VEC_W-1:0] vec
);
  logic             pend_d;
  logic [VEC_W-1:0] vec_d;
  logic             upd_en;

  assign upd_en = set_en || clr;

  always_comb begin
    pend_d = pend;
    vec_d  = vec;
    if (clr) begin
      pend_d = 1'b0;
    end else if (set_en) begin
      pend_d = 1'b1;
      vec_d  = set_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      vec  <= '0;
    end else if (upd_en) begin
      pend <= pend_d;
      vec  <= vec_d;
    end
  end

  // R6
  spc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr) |=> (pend && vec == $past(set_vec)));

  // R8
  spc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pend && $stable(vec)));

endmodule

// File: rtl/irq_track.sv
module irq_track
  import irq_track_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VEC_W-1:0]         req_vector,
  input  logic [2:0]               req_mode,
  input  logic                     ack,
  input  logic                     eoi,
  input  logic [NUM_SPC-1:0]       spc_ack,
  output logic [VEC_W-1:0]         top_req_vec,
  output logic [VEC_W-1:0]         top_svc_vec,
  output logic [NUM_SPC-1:0]       spc_pend,
  output logic [NUM_SPC*VEC_W-1:0] spc_vec,
  output logic                     unmask_pend
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [NUM_VEC-1:0] req_bits, svc_bits;
  logic               req_any, svc_any;
  logic               fixed_hit, ack_go, eoi_go;

  assign fixed_hit = req_valid && (req_mode == DM_FIXED || req_mode == DM_LOWPRI);
  assign ack_go    = ack && req_any;
  assign eoi_go    = eoi && svc_any;

  irq_vec_set #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_req_set (
    .clk(clk), .rst_n(rst_n_s),
    .set_en(fixed_hit), .set_vec(req_vector),
    .clr_en(ack_go),    .clr_vec(top_req_vec),
    .bits(req_bits));

  irq_vec_set #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_svc_set (
    .clk(clk), .rst_n(rst_n_s),
    .set_en(ack_go), .set_vec(top_req_vec),
    .clr_en(eoi_go), .clr_vec(top_svc_vec),
    .bits(svc_bits));

  irq_msb_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_req_scan (
    .bits(req_bits), .any(req_any), .top(top_req_vec));

  irq_msb_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_svc_scan (
    .bits(svc_bits), .any(svc_any), .top(top_svc_vec));

  for (genvar i = 0; i < NUM_SPC; i++) begin : g_spc
    logic hit;
    assign hit = req_valid && (req_mode == spc_code(i));
    irq_special_src #(.VEC_W(VEC_W)) u_src (
      .clk(clk), .rst_n(rst_n_s),
      .set_en(hit), .set_vec(req_vector), .clr(spc_ack[i]),
      .pend(spc_pend[i]), .vec(spc_vec[i*VEC_W +: VEC_W]));
  end

  assign unmask_pend = spc_pend[SPC_SMI] | spc_pend[SPC_NMI] | spc_pend[SPC_INI];

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_go |=> !req_bits[$past(top_req_vec)]);

  // R4
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_go && !(eoi_go && top_svc_vec == top_req_vec)) |=> svc_bits[$past(top_req_vec)]);

  // R5
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    eoi_go |=> !svc_bits[$past(top_svc_vec)]);

  // R3
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!req_any |-> top_req_vec == '0) and (!svc_any |-> top_svc_vec == '0));

  // R10
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && (req_mode == DM_RSV3 || req_mode == DM_RSV6) && !ack && !eoi && spc_ack == '0)
      |=> ($stable(req_bits) && $stable(svc_bits) && $stable(spc_pend)));

  // R7
  ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (spc_pend == (NUM_SPC'(1) << SPC_EXT)) |-> !unmask_pend);

endmodule

// File: tb/irq_track_bench.sv
module irq_track_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_vector;
  logic [2:0]  req_mode;
  logic        ack, eoi;
  logic [3:0]  spc_ack;
  logic [7:0]  top_req_vec, top_svc_vec;
  logic [3:0]  spc_pend;
  logic [31:0] spc_vec;
  logic        unmask_pend;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [255:0] m_req, m_svc;
  logic [3:0]   m_pend;
  logic [31:0]  m_vec;

  always #5 clk = ~clk;

  irq_track u_irq_track (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_mode(req_mode), .ack(ack), .eoi(eoi), .spc_ack(spc_ack),
    .top_req_vec(top_req_vec), .top_svc_vec(top_svc_vec), .spc_pend(spc_pend),
    .spc_vec(spc_vec), .unmask_pend(unmask_pend));

  function automatic logic [7:0] top_of(input logic [255:0] s);
    logic [7:0] r = 8'd0;
    for (int i = 0; i < 256; i++) if (s[i]) r = 8'(i);
    return r;
  endfunction

  function automatic int spc_index(input logic [2:0] m);
    case (m)
      3'd2: return 0;
      3'd4: return 1;
      3'd5: return 2;
      3'd7: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "top_req_vec", 32'(top_req_vec), 32'(top_of(m_req)));
    chk(tag, "top_svc_vec", 32'(top_svc_vec), 32'(top_of(m_svc)));
    chk(tag, "spc_pend", 32'(spc_pend), 32'(m_pend));
    chk(tag, "spc_vec", spc_vec, m_vec);
    chk(tag, "unmask_pend", 32'(unmask_pend), 32'(|m_pend[2:0]));
  endtask

  // drive one cycle at the falling edge, model the edge, check just after it
  task automatic step(input string tag, input logic rv, input logic [7:0] v, input logic [2:0] md,
                      input logic a, input logic e, input logic [3:0] sa);
    logic [255:0] n_req, n_svc;
    logic [3:0]   n_pend;
    logic [31:0]  n_vec;
    int           si;
    @(negedge clk);
    req_valid = rv; req_vector = v; req_mode = md; ack = a; eoi = e; spc_ack = sa;
    n_req = m_req; n_svc = m_svc; n_pend = m_pend; n_vec = m_vec;
    if (rv && (md == 3'd0 || md == 3'd1)) n_req[v] = 1'b1;
    if (a && m_req != '0) begin
      n_req[top_of(m_req)] = 1'b0;
      n_svc[top_of(m_req)] = 1'b1;
    end
    if (e && m_svc != '0) n_svc[top_of(m_svc)] = 1'b0;
    si = rv ? spc_index(md) : -1;
    for (int i = 0; i < 4; i++) begin
      if (sa[i]) n_pend[i] = 1'b0;
      else if (si == i) begin
        n_pend[i] = 1'b1;
        n_vec[i*8 +: 8] = v;
      end
    end
    @(posedge clk);
    #1;
    m_req = n_req; m_svc = n_svc; m_pend = n_pend; m_vec = n_vec;
    check_all(tag);
    req_valid = 0; ack = 0; eoi = 0; spc_ack = 4'd0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_vector = 0; req_mode = 0; ack = 0; eoi = 0; spc_ack = 0;
    m_req = '0; m_svc = '0; m_pend = '0; m_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    check_all("R1");

    step("R2", 1, 8'd200, 3'd0, 0, 0, 4'd0);
    chk("R2", "word6 bit8", 32'(top_req_vec), 32'd200);
    step("R11", 1, 8'd37, 3'd1, 0, 0, 4'd0);
    step("R2", 1, 8'd200, 3'd0, 0, 0, 4'd0);
    step("R10", 1, 8'd250, 3'd3, 0, 0, 4'd0);
    step("R10", 1, 8'd251, 3'd6, 0, 0, 4'd0);
    chk("R10", "ignored modes", 32'(top_req_vec), 32'd200);
    step("R4", 0, 8'd0, 3'd0, 1, 0, 4'd0);
    chk("R4", "moved to service", 32'(top_svc_vec), 32'd200);
    step("R9", 1, 8'd37, 3'd0, 1, 0, 4'd0);
    chk("R9", "dropped request", 32'(top_req_vec), 32'd0);
    step("R4", 0, 8'd0, 3'd0, 1, 0, 4'd0);
    step("R3", 0, 8'd0, 3'd0, 0, 0, 4'd0);
    step("R5", 0, 8'd0, 3'd0, 0, 1, 4'd0);
    chk("R5", "service after eoi", 32'(top_svc_vec), 32'd37);
    step("R5", 0, 8'd0, 3'd0, 0, 1, 4'd0);
    step("R3", 0, 8'd0, 3'd0, 0, 1, 4'd0);
    step("R2", 1, 8'd31, 3'd0, 0, 0, 4'd0);
    step("R2", 1, 8'd32, 3'd0, 0, 0, 4'd0);
    step("R2", 1, 8'd255, 3'd0, 0, 0, 4'd0);
    step("R4", 0, 8'd0, 3'd0, 1, 0, 4'd0);
    step("R4", 0, 8'd0, 3'd0, 1, 1, 4'd0);
    step("R6", 1, 8'h11, 3'd2, 0, 0, 4'd0);
    step("R6", 1, 8'h22, 3'd7, 0, 0, 4'd0);
    chk("R6", "pending set untouched", 32'(top_req_vec), 32'd31);
    step("R8", 0, 8'd0, 3'd0, 0, 0, 4'b0001);
    chk("R7", "external alone", 32'(unmask_pend), 32'd0);
    step("R6", 1, 8'h33, 3'd4, 0, 0, 4'd0);
    step("R6", 1, 8'h44, 3'd4, 0, 0, 4'd0);
    step("R9", 1, 8'h55, 3'd5, 0, 0, 4'b0100);
    step("R8", 0, 8'd0, 3'd0, 0, 0, 4'b1010);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] md;
      md = ($urandom % 10 < 6) ? 3'($urandom % 2) : 3'($urandom);
      step("R2/R4/R5/R6/R9", ($urandom % 10) < 7, 8'($urandom), md,
           ($urandom % 4) == 0, ($urandom % 5) == 0,
           4'(($urandom % 8 == 0) ? $urandom : 0));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule